// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a cascadable shift register of `WIDTH` stages (eight by default) that converts a parallel word into a serial bit stream. A level-sensitive mode input picks between two behaviours. In load mode, every stage follows its parallel input. In shift mode, the contents move one place toward the output on each rising edge of an effective shift clock. Stage 0 takes a serial input, so several registers can be chained. The last stage drives a true output and an inverted output.

The effective shift clock is the OR of a shift-clock input and a clock-inhibit input, so a rising edge on either line can advance the register. The block runs on a fast system clock and finds rising edges of the effective clock by sampling it. Each phase of the effective clock must therefore last at least two system clock cycles. Load mode is transparent: while it is held, the serial output shows the top parallel bit in the same cycle, and no clock edges have any effect.

Top module: `pload_shifter`

## Requirements
- R1: After reset, with shift mode selected and no clock edge, `serialOut` is 0 and `serialOutN` is 1.
- R2: While `shiftLoadN` is 0, `serialOut` equals `parIn[WIDTH-1]` in the same cycle, and the stages capture `parIn` on every system clock.
- R3: When `shiftLoadN` returns to 1, the loaded word stays in place. Successive rising edges then present `parIn[WIDTH-1]`, then `parIn[WIDTH-2]`, and so on down to `parIn[0]` at `serialOut`.
- R4: In shift mode, each detected rising edge of the effective clock moves every stage one place toward the output, and stage 0 captures `serialIn`. The new output is visible after the first system clock edge that sees the effective clock high.
- R5: `serialOutN` is always the complement of `serialOut`.
- R6: The effective clock is `shiftClk | clkInhibit`. A rising edge on either input while the other is low advances the register. While one input is held high, toggling the other input has no effect.
- R7: Rising edges that occur while `shiftLoadN` is 0 are ignored. An effective clock that is already high when load mode is released causes no shift.
- R8: Without a rising edge of the effective clock, the contents do not change. This covers falling edges and steady levels.
- R9: A bit taken from `serialIn` at one edge reaches `serialOut` after `WIDTH-1` further edges, so the register can be daisy-chained.
- R10: Each high phase of the effective clock, lasting at least two system clock cycles, produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| shiftLoadN | input | 1 | 1 = shift mode, 0 = transparent load |
| shiftClk | input | 1 | Shift clock, sampled on clk |
| clkInhibit | input | 1 | Clock inhibit, ORed with shiftClk |
| serialIn | input | 1 | Serial data into stage 0 |
| parIn | input | WIDTH | Parallel load word; bit WIDTH-1 goes to the output stage |
| serialOut | output | 1 | Last-stage output |
| serialOutN | output | 1 | Inverted last-stage output |

## Verification
In load mode, the output must follow `parIn[WIDTH-1]` in the same cycle, so the bench checks it one time step after driving the inputs. A shift becomes visible after the first rising edge of `clk` that sees the effective clock high. The bench raises the clock line at a falling edge of `clk` and samples at the next falling edge. Each ignored stimulus (a falling edge, a second line toggled while the first is held high, an edge during load, or a clock still high at load release) is followed by at least two idle cycles. The bench reads the output before it issues any new edge.

// File: rtl/pload_pkg.sv
package pload_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } shiftStrobe_t;
endpackage

// File: rtl/pload_ctrl.sv
module pload_ctrl
  import pload_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         shiftLoadN,
  input  logic         shiftClk,
  input  logic         clkInhibit,
  output shiftStrobe_t strobes
);
  logic effClk;
  logic clkPrev;

  assign effClk = shiftClk | clkInhibit;

  // history resets high so a line already high after reset is not an edge
  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= effClk;
  end

  always_comb begin
    strobes.load    = ~shiftLoadN;
    strobes.advance = effClk & ~clkPrev & shiftLoadN;
  end

  // R10: one shift per high phase
  a_r10_one_per_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> !strobes.advance);
endmodule

// File: rtl/pload_datapath.sv
module pload_datapath
  import pload_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobe_t     strobes,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serialOut,
  output logic             serialOutN
);
  localparam int MSB = WIDTH - 1;

  logic [MSB:0] stageQ;
  logic [MSB:0] stageD;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shiftSrc;
    if (i == 0) begin : g_first
      assign shiftSrc = serialIn;
    end else begin : g_chain
      assign shiftSrc = stageQ[i-1];
    end
    always_comb begin
      if (strobes.load)         stageD[i] = parIn[i];
      else if (strobes.advance) stageD[i] = shiftSrc;
      else                      stageD[i] = stageQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= stageD;
  end

  logic outBit;
  assign outBit     = strobes.load ? parIn[MSB] : stageQ[MSB];
  assign serialOut  = outBit;
  assign serialOutN = ~outBit;

  // R2: load captures the parallel word
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> stageQ == $past(parIn));
  // R4: one step toward the output with serialIn entering stage 0
  a_r4_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.load) |=>
      stageQ == {$past(stageQ[MSB-1:0]), $past(serialIn)});
  // R8: contents hold without an edge
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.load) |=> $stable(stageQ));
  // R7: control never advances during load
  a_r7_no_edge_in_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !strobes.advance);
endmodule

// File: rtl/pload_shifter.sv
module pload_shifter
  import pload_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftLoadN,
  input  logic             shiftClk,
  input  logic             clkInhibit,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serialOut,
  output logic             serialOutN
);
  shiftStrobe_t strobes;

  pload_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .shiftLoadN (shiftLoadN),
    .shiftClk   (shiftClk),
    .clkInhibit (clkInhibit),
    .strobes    (strobes)
  );

  pload_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .serialIn   (serialIn),
    .parIn      (parIn),
    .serialOut  (serialOut),
    .serialOutN (serialOutN)
  );
endmodule

// File: tb/pload_shifter_tb.sv
module pload_shifter_tb;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rstN, shiftLoadN, shiftClk, clkInhibit, serialIn;
  logic [WIDTH-1:0] parIn;
  logic serialOut, serialOutN;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [WIDTH-1:0] model;

  always #5 clk = ~clk;

  pload_shifter #(.WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .shiftLoadN(shiftLoadN), .shiftClk(shiftClk),
    .clkInhibit(clkInhibit), .serialIn(serialIn), .parIn(parIn),
    .serialOut(serialOut), .serialOutN(serialOutN)
  );

  function automatic logic [WIDTH-1:0] shiftModel(logic [WIDTH-1:0] cur, logic sin);
    return {cur[WIDTH-2:0], sin};
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(string req, logic exp);
    check(req, serialOut, exp);
    check("R5", serialOutN, ~exp);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2/R7: transparent load with clock activity that must be ignored
  task automatic doLoad(logic [WIDTH-1:0] val);
    shiftLoadN = 1'b0;
    parIn = val;
    #1 checkOut("R2", val[WIDTH-1]);
    @(negedge clk);
    shiftClk = 1'b1; tick(); tick();
    shiftClk = 1'b0; tick(); tick();
    shiftLoadN = 1'b1;
    parIn = ~val;
    model = val;
    tick();
    checkOut("R3", model[WIDTH-1]);
  endtask

  // R4/R6/R8/R10: one high phase on the chosen line
  task automatic pulse(bit useInhibit, logic sin);
    serialIn = sin;
    if (useInhibit) clkInhibit = 1'b1; else shiftClk = 1'b1;
    tick();
    model = shiftModel(model, sin);
    checkOut(useInhibit ? "R6" : "R4", model[WIDTH-1]);
    tick();
    checkOut("R10", model[WIDTH-1]);
    serialIn = ~sin;
    if (useInhibit) clkInhibit = 1'b0; else shiftClk = 1'b0;
    tick(); tick();
    checkOut("R8", model[WIDTH-1]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; shiftLoadN = 1'b1; shiftClk = 1'b0; clkInhibit = 1'b0;
    serialIn = 1'b0; parIn = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    checkOut("R1", 1'b0);

    // R3: a directed word comes out MSB first
    doLoad(8'b1011_0010);
    for (int i = WIDTH - 1; i >= 1; i--) begin
      pulse(1'b0, 1'b0);
      check("R3", serialOut, model[WIDTH-1]);
    end

    // R9: daisy-chain bits travel through all stages
    doLoad(8'h00);
    pulse(1'b0, 1'b1);
    for (int i = 0; i < WIDTH - 2; i++) pulse(1'b1, 1'b0);
    check("R9", serialOut, 1'b0);
    pulse(1'b0, 1'b0);
    check("R9", serialOut, 1'b1);

    // R6: inhibit held high blocks shift-clock edges
    doLoad(8'h80);
    clkInhibit = 1'b1;
    tick();
    model = shiftModel(model, serialIn);
    tick();
    checkOut("R6", model[WIDTH-1]);
    shiftClk = 1'b1; tick(); tick();
    shiftClk = 1'b0; tick(); tick();
    checkOut("R6", model[WIDTH-1]);
    clkInhibit = 1'b0; tick(); tick();
    checkOut("R8", model[WIDTH-1]);

    // R7: clock already high at load release is not an edge
    parIn = 8'h55;
    shiftLoadN = 1'b0;
    shiftClk = 1'b1;
    tick(); tick();
    shiftLoadN = 1'b1;
    model = 8'h55;
    parIn = 8'hAA;
    tick(); tick();
    checkOut("R7", model[WIDTH-1]);
    shiftClk = 1'b0; tick(); tick();
    checkOut("R7", model[WIDTH-1]);
    pulse(1'b0, 1'b1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      if (($urandom % 4) == 0) doLoad(WIDTH'($urandom));
      else pulse(1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule